// File: doc/BRIEF.md
# User-Level Trap Control and Status Unit

This unit keeps the control and status registers that let a small processor with only machine and user privilege handle selected traps entirely in user mode. Software reaches the registers through a CSR read/write port addressed by a 12-bit CSR number. The pipeline presents trap-entry requests with a cause code, the faulting PC and a trap value. The pipeline also asserts a strobe when it executes the user trap-return instruction. Two delegation masks arrive from outside, one for interrupts and one for exceptions. Only a delegated request is taken at user level.

When a delegated trap is taken, the unit stacks the interrupt-enable bit, records the exception PC, cause and trap value, and gives the trap vector base as the redirect target in that same cycle. On a trap return it pops the enable stack, gives the saved exception PC as the redirect target, and clears the per-trap registers so that no stale values remain after the handler. It also raises a request whenever an enabled, pending and delegated user interrupt exists while user interrupts are globally enabled. No previous-privilege field is kept, because the trapped mode can only be user mode.

Top module: `utrap_csr_unit`

## Requirements
- R1: After reset every mapped CSR reads 0, and irq_req and redirect_valid are 0.
- R2: CSR numbers map as status 0x000, enable 0x004, vector base 0x005, scratch 0x040, exception PC 0x041, cause 0x042, trap value 0x043, pending 0x044. A write takes effect at the next clock edge and reads are combinational. Any other number reads 0, and a write to it changes no register.
- R3: Status keeps only bit 0 (enable, EN) and bit 4 (previous enable, PEN), and its other bits read 0. The enable and pending CSRs keep IRQ_N low bits. The vector base reads with bits 1:0 as 0. The exception PC reads with bit 0 as 0, whether it is loaded by a write or by trap entry.
- R4: irq_req is 1 exactly when status bit 0 is 1 and (enable AND pending AND irq_deleg) is non-zero.
- R5: A delegated trap entry sets PEN to the old EN and clears EN. It loads the exception PC from trap_pc with bit 0 cleared and loads the trap value from trap_tval. In the same cycle it drives redirect_valid=1 and redirect_pc to the vector base.
- R6: On trap entry the cause CSR reads trap_code in its low bits, with bit 31 set for an interrupt (trap_is_irq=1) and clear for an exception.
- R7: A trap is delegated when bit trap_code of irq_deleg (interrupts) or exc_deleg (exceptions) is 1. An interrupt code of IRQ_N or more is never delegated. A request that is not delegated changes no register and gives no redirect.
- R8: A trap return sets EN to the old PEN and sets PEN to 1. It clears the exception PC, cause and trap value to 0. In the same cycle it drives redirect_valid=1 and redirect_pc to the exception PC held before the return.
- R9: In one cycle, a taken trap entry beats a trap return and a CSR write, and a trap return beats a CSR write. The losing write is discarded.
- R10: The pending CSR reads the OR of its software-written bits and hw_irq. hw_irq bits cannot be cleared by a write.
- R11: irq_code gives the lowest index among the enabled, pending and delegated interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | CSR number for read and write |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| trap_valid | input | 1 | Trap-entry request from pipeline |
| trap_is_irq | input | 1 | Request is an interrupt (1) or exception (0) |
| trap_code | input | CODE_W | Interrupt or exception code |
| trap_pc | input | 32 | PC of the trapping instruction |
| trap_tval | input | 32 | Faulting address or instruction |
| uret | input | 1 | User trap-return strobe |
| irq_deleg | input | IRQ_N | Interrupts delegated to user level |
| exc_deleg | input | 2**CODE_W | Exceptions delegated to user level |
| hw_irq | input | IRQ_N | Hardware interrupt pending lines |
| irq_req | output | 1 | Enabled user interrupt is pending |
| irq_code | output | CODE_W | Code of the lowest pending interrupt |
| redirect_valid | output | 1 | Fetch must redirect this cycle |
| redirect_pc | output | 32 | Redirect target |

## Verification
The status stack is tested with trap entry and return starting from each EN/PEN combination. A return with PEN=0 separates a correct pop from a design that only sets EN. Interrupt gating is tested by changing the global enable, the per-line enable, pending and delegation one at a time, and by using two active lines so that priority order is visible. Same-cycle mixes of trap, return and CSR write show which event wins. Requests that are not delegated, and writes to unmapped numbers, are checked through readback of every register they could have changed.

// File: rtl/utrap_pkg.sv
package utrap_pkg;
    localparam int XLEN = 32;

    localparam logic [11:0] CSR_STATUS  = 12'h000;
    localparam logic [11:0] CSR_IE      = 12'h004;
    localparam logic [11:0] CSR_TVEC    = 12'h005;
    localparam logic [11:0] CSR_SCRATCH = 12'h040;
    localparam logic [11:0] CSR_EPC     = 12'h041;
    localparam logic [11:0] CSR_CAUSE   = 12'h042;
    localparam logic [11:0] CSR_TVAL    = 12'h043;
    localparam logic [11:0] CSR_IP      = 12'h044;

    localparam int ST_EN  = 0;
    localparam int ST_PEN = 4;
endpackage

// File: rtl/utrap_deleg_chk.sv
module utrap_deleg_chk #(
    parameter int IRQ_N  = 16,
    parameter int CODE_W = 5
) (
    input  logic                     req,
    input  logic                     is_irq,
    input  logic [CODE_W-1:0]        code,
    input  logic [IRQ_N-1:0]         irq_mask,
    input  logic [(1<<CODE_W)-1:0]   exc_mask,
    output logic                     take
);
    localparam int CODE_N = 1 << CODE_W;

    logic [CODE_N-1:0] irq_wide;

    always_comb begin
        irq_wide = CODE_N'(irq_mask);
        take     = req && (is_irq ? irq_wide[code] : exc_mask[code]);
    end
endmodule

// File: rtl/utrap_irq_pick.sv
module utrap_irq_pick #(
    parameter int IRQ_N  = 16,
    parameter int CODE_W = 5
) (
    input  logic [IRQ_N-1:0]  active,
    output logic              any,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        any  = |active;
        code = '0;
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (active[i]) code = CODE_W'(i);
        end
    end
endmodule

// File: rtl/utrap_csr_rd.sv
module utrap_csr_rd
    import utrap_pkg::*;
#(
    parameter int IRQ_N = 16
) (
    input  logic [11:0]      addr,
    input  logic             en,
    input  logic             pen,
    input  logic [IRQ_N-1:0] ie,
    input  logic [IRQ_N-1:0] ip,
    input  logic [XLEN-1:0]  tvec,
    input  logic [XLEN-1:0]  scratch,
    input  logic [XLEN-1:0]  epc,
    input  logic [XLEN-1:0]  cause,
    input  logic [XLEN-1:0]  tval,
    output logic [XLEN-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            CSR_STATUS: begin
                rdata[ST_EN]  = en;
                rdata[ST_PEN] = pen;
            end
            CSR_IE:      rdata = XLEN'(ie);
            CSR_TVEC:    rdata = tvec;
            CSR_SCRATCH: rdata = scratch;
            CSR_EPC:     rdata = epc;
            CSR_CAUSE:   rdata = cause;
            CSR_TVAL:    rdata = tval;
            CSR_IP:      rdata = XLEN'(ip);
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/utrap_csr_unit.sv
module utrap_csr_unit
    import utrap_pkg::*;
#(
    parameter int IRQ_N  = 16,
    parameter int CODE_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [11:0]            csr_addr,
    input  logic                   csr_we,
    input  logic [31:0]            csr_wdata,
    output logic [31:0]            csr_rdata,
    input  logic                   trap_valid,
    input  logic                   trap_is_irq,
    input  logic [CODE_W-1:0]      trap_code,
    input  logic [31:0]            trap_pc,
    input  logic [31:0]            trap_tval,
    input  logic                   uret,
    input  logic [IRQ_N-1:0]       irq_deleg,
    input  logic [(1<<CODE_W)-1:0] exc_deleg,
    input  logic [IRQ_N-1:0]       hw_irq,
    output logic                   irq_req,
    output logic [CODE_W-1:0]      irq_code,
    output logic                   redirect_valid,
    output logic [31:0]            redirect_pc
);
    localparam int CAUSE_PAD = XLEN - 1 - CODE_W;

    typedef struct packed {
        logic             en;
        logic             pen;
        logic [IRQ_N-1:0] ie;
        logic [IRQ_N-1:0] ip_sw;
        logic [XLEN-1:0]  tvec;
        logic [XLEN-1:0]  scratch;
        logic [XLEN-1:0]  epc;
        logic [XLEN-1:0]  cause;
        logic [XLEN-1:0]  tval;
    } ustate_t;

    ustate_t          st_d, st_q;
    logic             take;
    logic             irq_any;
    logic [IRQ_N-1:0] pend;
    logic [IRQ_N-1:0] active;

    utrap_deleg_chk #(.IRQ_N(IRQ_N), .CODE_W(CODE_W)) i_deleg (
        .req      (trap_valid),
        .is_irq   (trap_is_irq),
        .code     (trap_code),
        .irq_mask (irq_deleg),
        .exc_mask (exc_deleg),
        .take     (take)
    );

    always_comb begin
        pend   = st_q.ip_sw | hw_irq;
        active = st_q.ie & pend & irq_deleg;
    end

    utrap_irq_pick #(.IRQ_N(IRQ_N), .CODE_W(CODE_W)) i_pick (
        .active (active),
        .any    (irq_any),
        .code   (irq_code)
    );

    assign irq_req = st_q.en && irq_any;

    utrap_csr_rd #(.IRQ_N(IRQ_N)) i_rd (
        .addr    (csr_addr),
        .en      (st_q.en),
        .pen     (st_q.pen),
        .ie      (st_q.ie),
        .ip      (pend),
        .tvec    (st_q.tvec),
        .scratch (st_q.scratch),
        .epc     (st_q.epc),
        .cause   (st_q.cause),
        .tval    (st_q.tval),
        .rdata   (csr_rdata)
    );

    always_comb begin
        st_d           = st_q;
        redirect_valid = take || uret;
        redirect_pc    = take ? st_q.tvec : st_q.epc;
        if (take) begin
            st_d.pen   = st_q.en;
            st_d.en    = 1'b0;
            st_d.epc   = trap_pc & ~32'h1;
            st_d.cause = {trap_is_irq, {CAUSE_PAD{1'b0}}, trap_code};
            st_d.tval  = trap_tval;
        end else if (uret) begin
            st_d.en    = st_q.pen;
            st_d.pen   = 1'b1;
            st_d.epc   = '0;
            st_d.cause = '0;
            st_d.tval  = '0;
        end else if (csr_we) begin
            unique case (csr_addr)
                CSR_STATUS: begin
                    st_d.en  = csr_wdata[ST_EN];
                    st_d.pen = csr_wdata[ST_PEN];
                end
                CSR_IE:      st_d.ie      = csr_wdata[IRQ_N-1:0];
                CSR_TVEC:    st_d.tvec    = csr_wdata & ~32'h3;
                CSR_SCRATCH: st_d.scratch = csr_wdata;
                CSR_EPC:     st_d.epc     = csr_wdata & ~32'h1;
                CSR_CAUSE:   st_d.cause   = csr_wdata;
                CSR_TVAL:    st_d.tval    = csr_wdata;
                CSR_IP:      st_d.ip_sw   = csr_wdata[IRQ_N-1:0];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/utrap_csr_chk.sv
module utrap_csr_chk #(
    parameter int IRQ_N  = 16,
    parameter int CODE_W = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   trap_valid,
    input logic                   trap_is_irq,
    input logic [CODE_W-1:0]      trap_code,
    input logic                   uret,
    input logic [IRQ_N-1:0]       irq_deleg,
    input logic [(1<<CODE_W)-1:0] exc_deleg,
    input logic                   irq_req,
    input logic                   redirect_valid,
    input logic [31:0]            redirect_pc,
    input logic                   st_en,
    input logic                   st_pen,
    input logic [31:0]            st_tvec,
    input logic [31:0]            st_epc,
    input logic [31:0]            st_cause,
    input logic [31:0]            st_tval
);
    logic deleg_ok;
    always_comb begin
        if (trap_is_irq)
            deleg_ok = (int'(trap_code) < IRQ_N) && ((irq_deleg >> trap_code) != '0)
                       && (((irq_deleg >> trap_code) & IRQ_N'(1)) != '0);
        else
            deleg_ok = ((exc_deleg >> trap_code) & 1) != 0;
    end

    AST_TRAP_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && deleg_ok) |=> (!st_en && st_pen == $past(st_en))) else $error("stack"); // R5
    AST_TRAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && deleg_ok) |-> (redirect_valid && redirect_pc == st_tvec)) else $error("target"); // R5
    AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (uret && !(trap_valid && deleg_ok)) |=>
        (st_pen && st_en == $past(st_pen) && st_epc == 0 && st_cause == 0 && st_tval == 0)) else $error("pop"); // R8
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_en |-> !irq_req) else $error("gate"); // R4
    AST_NO_DELEG: assert property (@(posedge clk) disable iff (!rst_n)
        (!(trap_valid && deleg_ok) && !uret) |-> !redirect_valid) else $error("nodeleg"); // R7
    AST_EPC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_epc[0] == 1'b0) else $error("epc"); // R3
    AST_CAUSE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && deleg_ok) |=> (st_cause[31] == $past(trap_is_irq))) else $error("cause"); // R6
endmodule

bind utrap_csr_unit utrap_csr_chk #(.IRQ_N(IRQ_N), .CODE_W(CODE_W)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_valid     (trap_valid),
    .trap_is_irq    (trap_is_irq),
    .trap_code      (trap_code),
    .uret           (uret),
    .irq_deleg      (irq_deleg),
    .exc_deleg      (exc_deleg),
    .irq_req        (irq_req),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .st_en          (st_q.en),
    .st_pen         (st_q.pen),
    .st_tvec        (st_q.tvec),
    .st_epc         (st_q.epc),
    .st_cause       (st_q.cause),
    .st_tval        (st_q.tval)
);

// File: tb/test_utrap_csr_unit.sv
`timescale 1ns/1ps
module test_utrap_csr_unit;
    localparam int IRQ_N  = 16;
    localparam int CODE_W = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        trap_valid = 1'b0;
    logic        trap_is_irq = 1'b0;
    logic [CODE_W-1:0] trap_code = '0;
    logic [31:0] trap_pc = '0;
    logic [31:0] trap_tval = '0;
    logic        uret = 1'b0;
    logic [IRQ_N-1:0] irq_deleg = '0;
    logic [31:0] exc_deleg = '0;
    logic [IRQ_N-1:0] hw_irq = '0;
    logic        irq_req;
    logic [CODE_W-1:0] irq_code;
    logic        redirect_valid;
    logic [31:0] redirect_pc;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    utrap_csr_unit #(.IRQ_N(IRQ_N), .CODE_W(CODE_W)) i_utrap_csr_unit (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .trap_valid(trap_valid),
        .trap_is_irq(trap_is_irq), .trap_code(trap_code), .trap_pc(trap_pc),
        .trap_tval(trap_tval), .uret(uret), .irq_deleg(irq_deleg),
        .exc_deleg(exc_deleg), .hw_irq(hw_irq), .irq_req(irq_req),
        .irq_code(irq_code), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_addr = a; csr_we = 1'b1; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        csr_addr = a;
        #1;
        chk(req, $sformatf("read %h", a), csr_rdata, exp);
    endtask

    task automatic t_reset;
        logic [11:0] addrs [8] = '{12'h000, 12'h004, 12'h005, 12'h040, 12'h041, 12'h042, 12'h043, 12'h044};
        for (int i = 0; i < 8; i++) rd_chk("R1", addrs[i], 32'h0);
        chk("R1", "irq_req", 32'(irq_req), 32'h0);
        chk("R1", "redirect_valid", 32'(redirect_valid), 32'h0);
    endtask

    task automatic t_map;
        logic [11:0] addrs [8] = '{12'h000, 12'h004, 12'h005, 12'h040, 12'h041, 12'h042, 12'h043, 12'h044};
        logic [31:0] exps  [8] = '{32'h11, 32'hFFFF, 32'hFFFFFFFC, 32'hFFFFFFFF,
                                    32'hFFFFFFFE, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFF};
        for (int i = 0; i < 8; i++) begin
            wr(addrs[i], 32'hFFFFFFFF);
            rd_chk((i == 0 || i == 2 || i == 4) ? "R3" : "R2", addrs[i], exps[i]);
        end
        for (int i = 0; i < 8; i++) wr(addrs[i], 32'h0);
        wr(12'h001, 32'hFFFFFFFF);
        rd_chk("R2", 12'h001, 32'h0);
        for (int i = 0; i < 8; i++) rd_chk("R2", addrs[i], 32'h0);
    endtask

    task automatic t_ip;
        @(negedge clk); hw_irq = 16'h0100;
        rd_chk("R10", 12'h044, 32'h100);
        wr(12'h044, 32'h0001);
        rd_chk("R10", 12'h044, 32'h101);
        wr(12'h044, 32'h0);
        rd_chk("R10", 12'h044, 32'h100);
        @(negedge clk); hw_irq = '0;
        rd_chk("R10", 12'h044, 32'h0);
    endtask

    task automatic t_irq;
        wr(12'h004, 32'h0030);
        wr(12'h044, 32'h0030);
        @(negedge clk); irq_deleg = 16'h0020; #1;
        chk("R4", "irq_req while EN=0", 32'(irq_req), 32'h0);
        wr(12'h000, 32'h1);
        #1;
        chk("R4", "irq_req EN=1", 32'(irq_req), 32'h1);
        chk("R11", "irq_code single", 32'(irq_code), 32'd5);
        @(negedge clk); irq_deleg = 16'h0030; #1;
        chk("R11", "irq_code lowest", 32'(irq_code), 32'd4);
        @(negedge clk); irq_deleg = 16'h0000; #1;
        chk("R4", "irq_req no deleg", 32'(irq_req), 32'h0);
        @(negedge clk); irq_deleg = 16'h0030;
        wr(12'h004, 32'h0);
        #1;
        chk("R4", "irq_req ie=0", 32'(irq_req), 32'h0);
        wr(12'h044, 32'h0);
        wr(12'h000, 32'h0);
        @(negedge clk); irq_deleg = '0;
    endtask

    task automatic pulse_trap(input logic is_irq, input logic [CODE_W-1:0] code,
                              input logic [31:0] pc, input logic [31:0] tv,
                              input string req, input logic exp_v, input logic [31:0] exp_pc);
        @(negedge clk);
        trap_valid = 1'b1; trap_is_irq = is_irq; trap_code = code; trap_pc = pc; trap_tval = tv;
        #1;
        chk(req, "redirect_valid", 32'(redirect_valid), 32'(exp_v));
        if (exp_v) chk(req, "redirect_pc", redirect_pc, exp_pc);
        @(negedge clk);
        trap_valid = 1'b0;
    endtask

    task automatic pulse_ret(input logic [31:0] exp_pc);
        @(negedge clk);
        uret = 1'b1;
        #1;
        chk("R8", "ret redirect_valid", 32'(redirect_valid), 32'h1);
        chk("R8", "ret redirect_pc", redirect_pc, exp_pc);
        @(negedge clk);
        uret = 1'b0;
    endtask

    task automatic t_exc_trap;
        wr(12'h000, 32'h1);
        wr(12'h005, 32'h1000);
        @(negedge clk); exc_deleg = 32'h4;
        pulse_trap(1'b0, 5'd2, 32'h2003, 32'hDEAD, "R5", 1'b1, 32'h1000);
        rd_chk("R5", 12'h000, 32'h10);
        rd_chk("R5", 12'h041, 32'h2002);
        rd_chk("R6", 12'h042, 32'h2);
        rd_chk("R5", 12'h043, 32'hDEAD);
    endtask

    task automatic t_ret;
        pulse_ret(32'h2002);
        rd_chk("R8", 12'h000, 32'h11);
        rd_chk("R8", 12'h041, 32'h0);
        rd_chk("R8", 12'h042, 32'h0);
        rd_chk("R8", 12'h043, 32'h0);
        wr(12'h000, 32'h1);
        pulse_ret(32'h0);
        rd_chk("R8", 12'h000, 32'h10);
    endtask

    task automatic t_irq_trap;
        @(negedge clk); irq_deleg = 16'h0010;
        pulse_trap(1'b1, 5'd4, 32'h3000, 32'h0, "R6", 1'b1, 32'h1000);
        rd_chk("R6", 12'h042, 32'h80000004);
        rd_chk("R5", 12'h000, 32'h00);
        rd_chk("R5", 12'h041, 32'h3000);
        pulse_ret(32'h3000);
        rd_chk("R8", 12'h000, 32'h10);
        @(negedge clk); irq_deleg = '0;
    endtask

    task automatic t_nodeleg;
        wr(12'h000, 32'h1);
        @(negedge clk); exc_deleg = 32'h0;
        pulse_trap(1'b0, 5'd3, 32'h7000, 32'h77, "R7", 1'b0, 32'h0);
        pulse_trap(1'b1, 5'd4, 32'h7000, 32'h77, "R7", 1'b0, 32'h0);
        @(negedge clk); irq_deleg = 16'hFFFF;
        pulse_trap(1'b1, 5'd20, 32'h7000, 32'h77, "R7", 1'b0, 32'h0);
        @(negedge clk); irq_deleg = '0;
        rd_chk("R7", 12'h000, 32'h1);
        rd_chk("R7", 12'h041, 32'h0);
        rd_chk("R7", 12'h042, 32'h0);
        rd_chk("R7", 12'h043, 32'h0);
    endtask

    task automatic t_collide;
        @(negedge clk); exc_deleg = 32'h4;
        @(negedge clk);
        trap_valid = 1'b1; trap_is_irq = 1'b0; trap_code = 5'd2; trap_pc = 32'h4000; trap_tval = 32'h1;
        csr_we = 1'b1; csr_addr = 12'h040; csr_wdata = 32'h55;
        @(negedge clk);
        trap_valid = 1'b0; csr_we = 1'b0;
        rd_chk("R9", 12'h040, 32'h0);
        rd_chk("R9", 12'h041, 32'h4000);
        rd_chk("R9", 12'h000, 32'h10);
        @(negedge clk);
        uret = 1'b1; csr_we = 1'b1; csr_addr = 12'h040; csr_wdata = 32'h66;
        @(negedge clk);
        uret = 1'b0; csr_we = 1'b0;
        rd_chk("R9", 12'h040, 32'h0);
        rd_chk("R9", 12'h000, 32'h11);
        @(negedge clk);
        trap_valid = 1'b1; trap_pc = 32'h5000; uret = 1'b1;
        #1;
        chk("R9", "trap+ret redirect_pc", redirect_pc, 32'h1000);
        @(negedge clk);
        trap_valid = 1'b0; uret = 1'b0;
        rd_chk("R9", 12'h000, 32'h10);
        rd_chk("R9", 12'h041, 32'h5000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_ip();
        t_irq();
        t_exc_trap();
        t_ret();
        t_irq_trap();
        t_nodeleg();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule